// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the register set of one storage channel. A host uses it to start and stop a DMA engine that walks a table of transfer descriptors in memory. It presents an 8-byte register window:

- a command byte at offset 0;
- a status byte at offset 2;
- a 32-bit descriptor table pointer at offset 4.

The bytes at offsets 1 and 3 are reserved. The host performs register accesses that carry a byte, half-word or word size code. The attached device reports the end of a transfer with a one-cycle completion pulse. Toward the DMA engine, the block emits a start strobe together with the descriptor pointer and an abort strobe. Toward the interrupt logic, it emits an interrupt-pending level.

The channel is controlled by a two-state machine:

- **CH_IDLE**: no transfer is in progress.
- **CH_RUN**: a transfer is in progress.

It has three transitions:

- **launch** (CH_IDLE to CH_RUN): a legal command write sets the run bit while a device is present and no completion pulse arrives in the same cycle.
- **halt** (CH_RUN to CH_IDLE): a legal command write clears the run bit. This issues an abort.
- **finish** (CH_RUN to CH_IDLE): the completion pulse arrives. This issues no abort and raises the interrupt bit.

If a launch is attempted with no device present, the machine stays in CH_IDLE and sets the status error bit. The command run bit and the status active bit both show whether the machine is in CH_RUN.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the command byte reads 0x00, the status byte reads 0x60 (both capability bits set), the pointer reads 0, and all strobes, acc_err and irq_pending are low.
- R2: A command write (offset 0, size code 0) with bit 0 = 1 while idle and a device present produces a one-cycle start_pulse in the cycle after the write. In that cycle start_ptr shows the pointer, and command bit 0 and status bit 0 read 1 from then on.
- R3: A command write with bit 0 = 0 while running produces a one-cycle abort_pulse, and command bit 0 and status bit 0 then read 0.
- R4: Command bit 3 (direction) takes the written value only when the write happens while idle. A write made while running, including the stopping write, leaves it unchanged.
- R5: Status bit 0 (active) cannot be changed by a status write.
- R6: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them and keep their value when 0 is written.
- R7: A pointer write (offset 4, size code 2) stores the data with bits 1:0 forced to zero.
- R8: Size codes are 0 for byte, 1 for half-word, 2 for word and 3 for illegal. Only byte writes at offsets 0 or 2 and word writes at offset 4 are legal. Any other write raises acc_err for one cycle after it and changes no register.
- R9: A completion pulse stops the channel without an abort and sets status bit 2, which drives irq_pending. When it arrives in the same cycle as a command write, the completion pulse takes priority.
- R10: A launch attempt with dev_present low produces no start_pulse, leaves the channel idle and sets status bit 1.
- R11: Writing 1 to the run bit while running produces no new start_pulse, and writing 0 to it while idle produces no abort_pulse.
- R12: Status bits 5 and 6 (capability flags) are plain read/write bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset within the window |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 illegal |
| wr_data | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data for acc_addr (combinational) |
| acc_err | output | 1 | One-cycle pulse after an illegal write |
| dev_present | input | 1 | A device is selected on the channel |
| dev_done | input | 1 | Transfer completion pulse from the device |
| start_pulse | output | 1 | One-cycle request to start the DMA engine |
| start_ptr | output | 32 | Descriptor pointer qualifying start_pulse |
| abort_pulse | output | 1 | One-cycle request to abort the transfer |
| irq_pending | output | 1 | Interrupt status bit |

## Verification
The bench sweeps every offset against every size code. A design with a loose legality check would either change a register on an illegal write or miss acc_err. It also writes all 256 status byte values over a state in which both the error and interrupt bits are set. This exposes a design that treats write-one-to-clear as plain storage, or that lets software touch the active bit. The direction lock is checked on the stopping write itself, where a design that looks at the new run bit instead of the old one would let direction change. A completion pulse coinciding with a stop write is also driven; a design that ranked the write first would emit a spurious abort.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int OFS_CMD = 0;
    localparam int OFS_STS = 2;
    localparam int OFS_PTR = 4;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam int STS_ACT_BIT  = 0;
    localparam int STS_ERR_BIT  = 1;
    localparam int STS_IRQ_BIT  = 2;
    localparam int STS_CAP0_BIT = 5;
    localparam int STS_CAP1_BIT = 6;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              cmd_wr,
    output logic              sts_wr,
    output logic              ptr_wr,
    output logic              bad_wr
);
    logic any_wr;

    always_comb begin
        any_wr = acc_valid && acc_write;
        cmd_wr = any_wr && (acc_addr == ADDR_W'(OFS_CMD)) && (acc_size == SZ_BYTE);
        sts_wr = any_wr && (acc_addr == ADDR_W'(OFS_STS)) && (acc_size == SZ_BYTE);
        ptr_wr = any_wr && (acc_addr == ADDR_W'(OFS_PTR)) && (acc_size == SZ_WORD);
        bad_wr = any_wr && !(cmd_wr || sts_wr || ptr_wr);
    end
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
    import dmareg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_run,
    input  logic cmd_dir,
    input  logic dev_present,
    input  logic dev_done,
    output logic run,
    output logic dir,
    output logic start_pulse,
    output logic abort_pulse,
    output logic nodev_err
);
    ch_state_e state_q, state_d;
    logic      launch_try;

    always_comb begin
        launch_try = cmd_wr && cmd_run && !dev_done;
        state_d    = state_q;
        unique case (state_q)
            CH_IDLE: if (launch_try && dev_present) state_d = CH_RUN;
            CH_RUN:  if (dev_done || (cmd_wr && !cmd_run)) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
        nodev_err = (state_q == CH_IDLE) && launch_try && !dev_present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            dir         <= 1'b0;
        end else begin
            start_pulse <= (state_q == CH_IDLE) && (state_d == CH_RUN);
            abort_pulse <= (state_q == CH_RUN) && (state_d == CH_IDLE) && !dev_done;
            if (cmd_wr && (state_q == CH_IDLE)) dir <= cmd_dir;
        end
    end

    assign run = (state_q == CH_RUN);

    p_start_enters_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> run);
    p_start_has_device_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(dev_present));
    p_abort_leaves_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!run && $past(run)));
    p_dir_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(dir));
    p_done_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_done |=> (!run && !abort_pulse));
endmodule

// File: rtl/dmareg_status.sv
module dmareg_status
    import dmareg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_wr,
    input  logic       clr_err,
    input  logic       clr_irq,
    input  logic [1:0] cap_in,
    input  logic       nodev_err,
    input  logic       dev_done,
    input  logic       active,
    output logic [7:0] status,
    output logic       irq
);
    logic       err_q, irq_q;
    logic [1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b11;
        end else begin
            if (nodev_err)                err_q <= 1'b1;
            else if (sts_wr && clr_err)   err_q <= 1'b0;
            if (dev_done)                 irq_q <= 1'b1;
            else if (sts_wr && clr_irq)   irq_q <= 1'b0;
            if (sts_wr)                   cap_q <= cap_in;
        end
    end

    always_comb begin
        status               = 8'h00;
        status[STS_ACT_BIT]  = active;
        status[STS_ERR_BIT]  = err_q;
        status[STS_IRQ_BIT]  = irq_q;
        status[STS_CAP0_BIT] = cap_q[0];
        status[STS_CAP1_BIT] = cap_q[1];
    end

    assign irq = irq_q;

    p_irq_rise_from_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(dev_done));
    p_w1c_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !clr_irq && irq_q) |=> irq_q);
    p_err_rise_from_nodev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(nodev_err));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmareg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    input  logic              dev_present,
    input  logic              dev_done,
    output logic              start_pulse,
    output logic [DATA_W-1:0] start_ptr,
    output logic              abort_pulse,
    output logic              irq_pending
);
    localparam logic [DATA_W-1:0] ALIGN_MASK = DATA_W'(3);

    logic              cmd_wr, sts_wr, ptr_wr, bad_wr;
    logic              run, dir, nodev_err;
    logic [7:0]        cmd_byte, sts_byte;
    logic [DATA_W-1:0] ptr_q;

    dmareg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .cmd_wr    (cmd_wr),
        .sts_wr    (sts_wr),
        .ptr_wr    (ptr_wr),
        .bad_wr    (bad_wr)
    );

    dmareg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_run     (wr_data[CMD_RUN_BIT]),
        .cmd_dir     (wr_data[CMD_DIR_BIT]),
        .dev_present (dev_present),
        .dev_done    (dev_done),
        .run         (run),
        .dir         (dir),
        .start_pulse (start_pulse),
        .abort_pulse (abort_pulse),
        .nodev_err   (nodev_err)
    );

    dmareg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_wr    (sts_wr),
        .clr_err   (wr_data[STS_ERR_BIT]),
        .clr_irq   (wr_data[STS_IRQ_BIT]),
        .cap_in    ({wr_data[STS_CAP1_BIT], wr_data[STS_CAP0_BIT]}),
        .nodev_err (nodev_err),
        .dev_done  (dev_done),
        .active    (run),
        .status    (sts_byte),
        .irq       (irq_pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            acc_err <= 1'b0;
        end else begin
            if (ptr_wr) ptr_q <= wr_data & ~ALIGN_MASK;
            acc_err <= bad_wr;
        end
    end

    always_comb begin
        cmd_byte              = 8'h00;
        cmd_byte[CMD_RUN_BIT] = run;
        cmd_byte[CMD_DIR_BIT] = dir;
        rd_data               = '0;
        if (acc_addr == ADDR_W'(OFS_CMD))      rd_data[7:0] = cmd_byte;
        else if (acc_addr == ADDR_W'(OFS_STS)) rd_data[7:0] = sts_byte;
        else if (acc_addr == ADDR_W'(OFS_PTR)) rd_data      = ptr_q;
    end

    assign start_ptr = ptr_q;

    p_err_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_valid && acc_write));
    p_ptr_needs_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size != SZ_WORD) |=> $stable(ptr_q));
    p_ptr_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ptr_wr) |-> (ptr_q[1:0] == 2'b00));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, dev_present, dev_done;
    logic [2:0]  acc_addr;
    logic [1:0]  acc_size;
    logic [31:0] wr_data, rd_data, start_ptr;
    logic        acc_err, start_pulse, abort_pulse, irq_pending;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .wr_data(wr_data), .rd_data(rd_data),
        .acc_err(acc_err), .dev_present(dev_present), .dev_done(dev_done),
        .start_pulse(start_pulse), .start_ptr(start_ptr), .abort_pulse(abort_pulse),
        .irq_pending(irq_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    logic sp, ap, ae;
    logic [31:0] sp_ptr;

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d,
                      input logic dn);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; wr_data = d;
        dev_done = dn;
        @(negedge clk);
        sp = start_pulse; ap = abort_pulse; ae = acc_err; sp_ptr = start_ptr;
        acc_valid = 1'b0; acc_write = 1'b0; dev_done = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_addr = a;
        #1 d = rd_data;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        dev_done = 1'b1;
        @(negedge clk);
        sp = start_pulse; ap = abort_pulse;
        dev_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        acc_size = '0; wr_data = '0; dev_present = 1'b1; dev_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd0, d); check("R1 cmd", d, 32'h00);
        rd(3'd2, d); check("R1 status", d, 32'h60);
        rd(3'd4, d); check("R1 ptr", d, 32'h0);
        check("R1 outputs", {28'd0, start_pulse, abort_pulse, acc_err, irq_pending}, 32'h0);

        // R7 pointer alignment sweep
        for (int i = 0; i < 32; i++) begin
            logic [31:0] v;
            v = 32'h1234_5673 ^ (i * 32'h0101_0105);
            wr(3'd4, 2'd2, v, 1'b0);
            check("R7 err", {31'd0, ae}, 32'h0);
            rd(3'd4, d); check("R7 ptr", d, v & 32'hFFFF_FFFC);
        end

        // R8 offset x size sweep
        for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 4; s++) begin
                logic legal;
                logic [31:0] dat, ecmd, ests, eptr;
                wr(3'd4, 2'd2, 32'hA5A5_A5A4, 1'b0);
                legal = (s == 0 && (a == 0 || a == 2)) || (s == 2 && a == 4);
                dat  = (a == 0) ? 32'h08 : (a == 2) ? 32'h00 : 32'h60;
                ecmd = (legal && a == 0) ? 32'h08 : 32'h00;
                ests = (legal && a == 2) ? 32'h00 : 32'h60;
                eptr = (legal && a == 4) ? 32'h60 : 32'hA5A5_A5A4;
                wr(3'(a), 2'(s), dat, 1'b0);
                check("R8 acc_err", {31'd0, ae}, {31'd0, !legal});
                rd(3'd0, d); check("R8 cmd", d, ecmd);
                rd(3'd2, d); check("R8 status", d, ests);
                rd(3'd4, d); check("R8 ptr", d, eptr);
                wr(3'd0, 2'd0, 32'h00, 1'b0);
                wr(3'd2, 2'd0, 32'h60, 1'b0);
            end
        end

        // R2 start, R4/R11 while running, R3 stop
        wr(3'd4, 2'd2, 32'h0000_1000, 1'b0);
        wr(3'd0, 2'd0, 32'h09, 1'b0);
        check("R2 start_pulse", {31'd0, sp}, 32'h1);
        check("R2 start_ptr", sp_ptr, 32'h0000_1000);
        rd(3'd0, d); check("R2 cmd", d, 32'h09);
        rd(3'd2, d); check("R2 status", d, 32'h61);
        check("R2 single pulse", {31'd0, start_pulse}, 32'h0);
        wr(3'd0, 2'd0, 32'h01, 1'b0);
        check("R11 no restart", {31'd0, sp}, 32'h0);
        rd(3'd0, d); check("R4 dir locked", d, 32'h09);
        wr(3'd0, 2'd0, 32'h00, 1'b0);
        check("R3 abort", {31'd0, ap}, 32'h1);
        rd(3'd0, d); check("R4 dir kept on stop", d, 32'h08);
        rd(3'd2, d); check("R3 status", d, 32'h60);
        wr(3'd0, 2'd0, 32'h00, 1'b0);
        check("R11 no abort idle", {31'd0, ap}, 32'h0);
        rd(3'd0, d); check("R4 dir writable idle", d, 32'h00);

        // R5 active read-only, R9 completion
        wr(3'd0, 2'd0, 32'h01, 1'b0);
        wr(3'd2, 2'd0, 32'h60, 1'b0);
        rd(3'd2, d); check("R5 active kept", d, 32'h61);
        done_pulse();
        check("R9 no abort", {31'd0, ap}, 32'h0);
        rd(3'd0, d); check("R9 cmd", d, 32'h00);
        rd(3'd2, d); check("R9 status", d, 32'h64);
        check("R9 irq_pending", {31'd0, irq_pending}, 32'h1);
        wr(3'd2, 2'd0, 32'h64, 1'b0);
        rd(3'd2, d); check("R6 irq cleared", d, 32'h60);
        wr(3'd2, 2'd0, 32'h61, 1'b0);
        rd(3'd2, d); check("R5 active idle", d, 32'h60);

        // R9 completion beats a stop write
        wr(3'd0, 2'd0, 32'h01, 1'b0);
        wr(3'd0, 2'd0, 32'h00, 1'b1);
        check("R9 priority no abort", {31'd0, ap}, 32'h0);
        rd(3'd2, d); check("R9 priority status", d, 32'h64);
        wr(3'd2, 2'd0, 32'h64, 1'b0);

        // R10 launch without device
        dev_present = 1'b0;
        wr(3'd0, 2'd0, 32'h01, 1'b0);
        check("R10 no start", {31'd0, sp}, 32'h0);
        rd(3'd0, d); check("R10 cmd", d, 32'h00);
        rd(3'd2, d); check("R10 status", d, 32'h62);
        wr(3'd2, 2'd0, 32'h62, 1'b0);
        rd(3'd2, d); check("R6 err cleared", d, 32'h60);

        // R6 / R12 full status byte sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            logic [31:0] e;
            b = 8'(v);
            wr(3'd0, 2'd0, 32'h01, 1'b0);
            done_pulse();
            wr(3'd2, 2'd0, {24'd0, b}, 1'b0);
            e = {25'd0, b[6], b[5], 2'b00, ~b[2], ~b[1], 1'b0};
            rd(3'd2, d); check("R6 R12 status sweep", d, e);
            check("R6 irq_pending", {31'd0, irq_pending}, {31'd0, ~b[2]});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule